// File: doc/BRIEF.md
# Master/Slave SPI Controller with Collision and Mode-Fault Detection

This block moves one byte at a time over a four-wire synchronous serial link. It can run as bus master, where it generates the serial clock from the system clock and drives the outgoing data line. It can also run as slave, where it follows a serial clock and select line driven by another device. Every transfer is full duplex: one byte is shifted out while the other is shifted in, most significant bit first. The clock idle level and the sampling edge are chosen by software, which gives four protocols.

Software reaches the block through a small register port with a control, a status and a data register. Pin drivers are separated into value and output-enable signals so that a pad ring can release the lines. Two error conditions are detected. A write to the data register during a transfer is refused and flagged. When a master sees its select input pulled low by another device, the block leaves master mode and releases its drivers at once. One interrupt line reports completion and errors.

The register port has no back-pressure. A data write that arrives during a transfer is dropped and recorded as a collision, and the transfer in progress keeps its byte. The pins carry plain levels. The slave-side inputs pass through a two-stage synchronizer, so a slave needs a serial clock at most about one eighth of the system clock.

Top module: `spi_ctl`

## Requirements
- R1: After reset, control (address 0), status (address 1) and the received-data register (address 2) read 0x00, the interrupt is low and every output enable is low. The control bits are: bit 7 interrupt enable, bit 6 block enable, bit 5 master select, bit 4 clock polarity, bit 3 clock phase, and bits 2:0 the rate code. The status bits are: bit 7 transfer done, bit 6 write collision, bit 5 mode fault, and bit 0 busy.
- R2: In master mode, a write to the data register while the block is idle starts an 8-bit full-duplex transfer, MSB first, in all four polarity/phase combinations. With phase 0, data is sampled on the leading edge. With phase 1, data is sampled on the trailing edge. Afterwards the data register reads the byte shifted in on the input line.
- R3: The master serial clock has a half period of 2^rate system clocks. A rate code above 4 behaves as 4, so the clock ranges from clk/2 to clk/32.
- R4: While no master transfer runs, the serial clock output rests at the level of the polarity bit.
- R5: In slave mode, an enabled slave whose select input is low exchanges a byte with the external master, in both phases.
- R6: A selected slave with phase 0 drives the MSB of its loaded byte on its output before the first clock edge. The slave output enable is high only while the block is an enabled, selected slave. The master clock and data enables are high only in master mode.
- R7: A data write during a transfer sets the collision flag (status bit 6) and leaves the outgoing byte unchanged.
- R8: Status bit 7 sets when a transfer completes. A slave completes on its eighth sampling edge, and a master completes after its sixteenth clock edge. Bit 7 and the collision flag clear only when a data-register access follows a status read that showed either of them set. A data read with no prior status read leaves them set.
- R9: If the select input goes low while the block is an enabled master, the mode-fault flag sets, the master bit clears, the clock and data drivers are released, and any transfer is aborted with the clock back at idle.
- R10: The mode-fault flag clears only when a control write follows a status read that showed it set.
- R11: The interrupt output equals the interrupt-enable bit ANDed with the OR of the done, collision and mode-fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (side effects only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Master-to-slave data, slave receive |
| mosi_o | output | 1 | Master-to-slave data, master transmit |
| mosi_oe | output | 1 | Master-to-slave data driver enable |
| miso_i | input | 1 | Slave-to-master data, master receive |
| miso_o | output | 1 | Slave-to-master data, slave transmit |
| miso_oe | output | 1 | Slave-to-master data driver enable |
| ss_n_i | input | 1 | Active-low slave select input |

## Verification
The master path runs one byte pair per mode and rate code, with an external slave model on the far end. The byte pairs (alternating bits, single set bit, all-ones against all-zeros, mirrored patterns) separate a bit-order or phase error from a stuck line. Measuring the first clock half period separates a wrong divider from a wrong clamp for codes above four. The slave path is driven in both phases at a slow clock, and the output is checked before the first edge. Collision, mode fault and the two-step flag clearing are each tried in their correct and incorrect orders.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic       ie;
    logic       en;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [2:0] rate;
  } ctrl_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int RATE_MAX = 4,
  localparam int CW = (RATE_MAX < 1) ? 1 : RATE_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       tick
);
  logic [CW-1:0] cnt;
  logic [2:0]    rate_eff;
  logic [CW:0]   half;
  logic [CW:0]   lim;

  always_comb begin
    rate_eff = (rate > 3'(RATE_MAX)) ? 3'(RATE_MAX) : rate;
    half     = (CW+1)'(1) << rate_eff;
    lim      = half - (CW+1)'(1);
    tick     = run && ({1'b0, cnt} == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8,
  localparam int EW = $clog2(2*DW),
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mstr,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          tick,
  input  logic          abort,
  input  logic          sck_s,
  input  logic          ss_s,
  input  logic          mosi_s,
  input  logic          miso_raw,
  output logic          mbusy,
  output logic          sel,
  output logic          sck_lvl,
  output logic          out_bit,
  output logic          done,
  output logic [DW-1:0] rx_data
);
  logic [DW-1:0] sr, sr_nxt;
  logic [EW-1:0] ecnt;
  logic [BW-1:0] bcnt;
  logic          tog, sck_d, out_q;
  logic          s_edge, lead, trail, samp, shft, in_bit, m_last, s_last;

  always_comb begin
    sel    = en && !mstr && !ss_s;
    s_edge = sel && (sck_s != sck_d);
    lead   = (tick && !ecnt[0]) || (s_edge && (sck_s != cpol));
    trail  = (tick &&  ecnt[0]) || (s_edge && (sck_s == cpol));
    samp   = cpha ? trail : lead;
    shft   = cpha ? lead  : trail;
    in_bit = mbusy ? miso_raw : mosi_s;
    sr_nxt = samp ? {sr[DW-2:0], in_bit} : sr;
    m_last = tick && !abort && (ecnt == EW'(2*DW-1));
    s_last = samp && sel && (bcnt == BW'(DW-1));
    done   = m_last || s_last;
  end

  assign sck_lvl = cpol ^ tog;
  assign out_bit = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      out_q   <= 1'b0;
      sck_d   <= 1'b0;
      bcnt    <= '0;
      rx_data <= '0;
    end else begin
      sck_d <= sck_s;
      if (tx_wr) sr <= tx_data;
      else       sr <= sr_nxt;
      if (tx_wr && !cpha)               out_q <= tx_data[DW-1];
      else if (shft)                    out_q <= sr[DW-1];
      else if (!mbusy && !sel && !cpha) out_q <= sr[DW-1];
      if (!sel)      bcnt <= '0;
      else if (samp) bcnt <= bcnt + BW'(1);
      if (done) rx_data <= sr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy <= 1'b0;
      ecnt  <= '0;
      tog   <= 1'b0;
    end else if (abort || !en || !mstr) begin
      mbusy <= 1'b0;
      ecnt  <= '0;
      tog   <= 1'b0;
    end else if (tx_wr) begin
      mbusy <= 1'b1;
      ecnt  <= '0;
      tog   <= 1'b0;
    end else if (tick) begin
      tog  <= ~tog;
      ecnt <= ecnt + EW'(1);
      if (m_last) mbusy <= 1'b0;
    end
  end

  p_tick_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> mbusy);
  p_idle_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mbusy |-> (sck_lvl == cpol));
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> (!mbusy && !sel));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [7:0]    wdata,
  input  logic          busy,
  input  logic          done_p,
  input  logic [DW-1:0] rx_data,
  input  logic          modf_det,
  output ctrl_t         ctrl_q,
  output logic          tx_wr,
  output logic [7:0]    rdata,
  output logic          irq
);
  logic done_f, wcol_f, modf_f, arm_d, arm_m;
  logic cwr, dwr, drd, dacc, srd;

  always_comb begin
    cwr   = wr && (addr == A_CTRL);
    dwr   = wr && (addr == A_DATA);
    drd   = rd && (addr == A_DATA);
    srd   = rd && (addr == A_STAT);
    dacc  = dwr || drd;
    tx_wr = dwr && !busy;
    irq   = ctrl_q.ie && (done_f || wcol_f || modf_f);
    case (addr)
      A_CTRL:  rdata = 8'(ctrl_q);
      A_STAT:  rdata = {done_f, wcol_f, modf_f, 4'b0000, busy};
      A_DATA:  rdata = 8'(rx_data);
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_f <= 1'b0;
      wcol_f <= 1'b0;
      modf_f <= 1'b0;
      arm_d  <= 1'b0;
      arm_m  <= 1'b0;
    end else begin
      if (cwr)      ctrl_q      <= ctrl_t'(wdata);
      if (modf_det) ctrl_q.mstr <= 1'b0;

      if (dacc && arm_d)                 arm_d <= 1'b0;
      else if (srd && (done_f || wcol_f)) arm_d <= 1'b1;

      if (done_p)              done_f <= 1'b1;
      else if (dacc && arm_d)  done_f <= 1'b0;

      if (dwr && busy)         wcol_f <= 1'b1;
      else if (dacc && arm_d)  wcol_f <= 1'b0;

      if (cwr && arm_m)        arm_m <= 1'b0;
      else if (srd && modf_f)  arm_m <= 1'b1;

      if (modf_det)            modf_f <= 1'b1;
      else if (cwr && arm_m)   modf_f <= 1'b0;
    end
  end

  p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && busy) |=> wcol_f);
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dacc && arm_d && !done_p) |=> !done_f);
  p_modf_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    modf_det |=> (modf_f && !ctrl_q.mstr));
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATE_MAX    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  localparam logic [2:0] SYNC_RST = 3'b010;

  ctrl_t         ctrl_q;
  logic [2:0]    syn [SYNC_STAGES];
  logic          sck_s, ss_s, mosi_s;
  logic          tick, tx_wr, done_p, mbusy, sel, busy, modf_det;
  logic          sck_lvl, out_bit;
  logic [DW-1:0] rx_data;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syn[g] <= SYNC_RST;
      else if (g == 0) syn[g] <= {sck_i, ss_n_i, mosi_i};
      else syn[g] <= syn[(g == 0) ? 0 : g-1];
    end
  end

  assign {sck_s, ss_s, mosi_s} = syn[SYNC_STAGES-1];
  assign busy     = mbusy || sel;
  assign modf_det = ctrl_q.en && ctrl_q.mstr && !ss_s;

  spi_regs u_regs (
    .clk, .rst_n,
    .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .busy, .done_p, .rx_data, .modf_det,
    .ctrl_q, .tx_wr, .rdata(reg_rdata), .irq
  );

  spi_rate_gen #(.RATE_MAX(RATE_MAX)) u_rate (
    .clk, .rst_n, .run(mbusy), .rate(ctrl_q.rate), .tick
  );

  spi_shift_core #(.DW(DW)) u_core (
    .clk, .rst_n,
    .en(ctrl_q.en), .mstr(ctrl_q.mstr), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
    .tx_wr, .tx_data(reg_wdata[DW-1:0]), .tick, .abort(modf_det),
    .sck_s, .ss_s, .mosi_s, .miso_raw(miso_i),
    .mbusy, .sel, .sck_lvl, .out_bit, .done(done_p), .rx_data
  );

  assign sck_o   = sck_lvl;
  assign mosi_o  = out_bit;
  assign miso_o  = out_bit;
  assign sck_oe  = ctrl_q.en && ctrl_q.mstr;
  assign mosi_oe = ctrl_q.en && ctrl_q.mstr;
  assign miso_oe = sel;

  p_drv_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe && (sck_oe || mosi_oe)));
  p_modf_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    modf_det |=> (!sck_oe && !mosi_oe));
endmodule

// File: tb/tb_spi_ctl.sv
`timescale 1ns/1ps
module tb_spi_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic       miso_i;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int n_run = 0, n_fail = 0;
  logic fin = 1'b0;

  always #2 clk = ~clk;

  spi_ctl dut (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata, .irq,
    .sck_i, .sck_o, .sck_oe, .mosi_i, .mosi_o, .mosi_oe,
    .miso_i, .miso_o, .miso_oe, .ss_n_i
  );

  // external slave model for master tests
  logic       m_act = 1'b0, c_cpol = 1'b0, c_cpha = 1'b0;
  logic [7:0] s_byte = 8'h00, t_rx;
  logic       sck_prev = 1'b0;
  int         sh, ecnt_t;
  realtime    t0, t1;

  always @(sck_o or posedge m_act) begin
    if (sck_o === sck_prev) begin
      sh = 0; ecnt_t = 0; t_rx = 8'h00;
    end else begin
      if (m_act) begin
        if (ecnt_t == 0) t0 = $realtime;
        else if (ecnt_t == 1) t1 = $realtime;
        ecnt_t++;
        if ((sck_o != c_cpol) ^ c_cpha) t_rx = {t_rx[6:0], mosi_o};
        else sh++;
      end
      sck_prev = sck_o;
    end
  end

  always_comb begin
    int idx;
    idx = c_cpha ? (8 - sh) : (7 - sh);
    miso_i = (idx >= 0 && idx <= 7) ? s_byte[idx[2:0]] : 1'b1;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
  endtask

  // drive one byte as an external master (half period 8 clocks)
  task automatic s_bits(input logic cp, input logic ph, input logic [7:0] mb,
                        output logic [7:0] got);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      if (!ph) begin
        mosi_i = mb[i];
        repeat (8) @(negedge clk); sck_i = ~cp; got[i] = miso_o;
        repeat (8) @(negedge clk); sck_i = cp;
      end else begin
        repeat (8) @(negedge clk); sck_i = ~cp;
        repeat (4) @(negedge clk); mosi_i = mb[i];
        repeat (4) @(negedge clk); sck_i = cp; got[i] = miso_o;
      end
    end
    repeat (8) @(negedge clk);
  endtask

  // {cpol, cpha, rate, master byte, slave byte}
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd1, 8'h96, 8'hE1},
    {1'b1, 1'b0, 3'd2, 8'h01, 8'h80},
    {1'b1, 1'b1, 3'd3, 8'hFF, 8'h00},
    {1'b0, 1'b0, 3'd7, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 3'd4, 8'h7E, 8'h81}
  };

  initial begin
    logic [7:0] v, got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 oe", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h00);

    // master vectors: R2, R3, R4, R8, R11
    for (int k = 0; k < NV; k++) begin
      logic cp, ph; logic [2:0] rt; logic [7:0] tx, sv; int hexp;
      {cp, ph, rt, tx, sv} = VEC[k];
      hexp = 1 << ((rt > 3'd4) ? 4 : rt);
      c_cpol = cp; c_cpha = ph; s_byte = sv;
      wr(2'd0, {3'b111, cp, ph, rt});
      @(negedge clk);
      chk("R4 idle sck", {7'b0, sck_o}, {7'b0, cp});
      m_act = 1'b1;
      wr(2'd2, tx);
      wait_irq();
      chk("R11 irq on done", {7'b0, irq}, 8'h01);
      m_act = 1'b0;
      rd(2'd1, v); chk("R8 done flag", v, 8'h80);
      rd(2'd2, v); chk("R2 master rx", v, sv);
      chk("R2 slave saw", t_rx, tx);
      chk("R3 half period", 8'($rtoi((t1 - t0) / 4.0)), 8'(hexp));
      rd(2'd1, v); chk("R8 cleared", v, 8'h00);
    end

    // R7 master collision
    c_cpol = 1'b0; c_cpha = 1'b0; s_byte = 8'h55;
    wr(2'd0, 8'hE2);
    m_act = 1'b1;
    wr(2'd2, 8'h33);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'hFF);
    chk("R11 irq on collision", {7'b0, irq}, 8'h01);
    repeat (100) @(negedge clk);
    m_act = 1'b0;
    rd(2'd1, v); chk("R7 collision flag", v, 8'hC0);
    chk("R7 byte unchanged", t_rx, 8'h33);
    rd(2'd2, v); chk("R7 rx", v, 8'h55);
    rd(2'd1, v); chk("R7 flags cleared", v, 8'h00);

    // R8 order, R11 masking
    s_byte = 8'h0F;
    wr(2'd0, 8'h60);
    m_act = 1'b1;
    wr(2'd2, 8'hF0);
    repeat (80) @(negedge clk);
    m_act = 1'b0;
    chk("R11 masked", {7'b0, irq}, 8'h00);
    wr(2'd0, 8'hE0);
    @(negedge clk);
    chk("R11 unmasked", {7'b0, irq}, 8'h01);
    rd(2'd2, v);
    rd(2'd1, v); chk("R8 data read alone keeps done", v, 8'h80);
    rd(2'd2, v); chk("R8 rx", v, 8'h0F);
    rd(2'd1, v); chk("R8 cleared after sequence", v, 8'h00);

    // R9, R10 mode fault
    wr(2'd0, 8'hE3);
    wr(2'd2, 8'hAA);
    repeat (5) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 drivers released", {6'b0, sck_oe, mosi_oe}, 8'h00);
    chk("R9 sck idle", {7'b0, sck_o}, 8'h00);
    chk("R11 irq on fault", {7'b0, irq}, 8'h01);
    rd(2'd0, v); chk("R9 master bit cleared", v, 8'hC3);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'hC3);
    rd(2'd1, v); chk("R10 fault kept", v, 8'h20);
    wr(2'd0, 8'hC3);
    rd(2'd1, v); chk("R10 fault cleared", v, 8'h00);

    // R5, R6 slave phase 0
    wr(2'd0, 8'hC0);
    sck_i = 1'b0;
    wr(2'd2, 8'hA5);
    @(negedge clk);
    chk("R6 slave oe idle", {7'b0, miso_oe}, 8'h00);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 slave oe selected", {6'b0, miso_oe, sck_oe}, 8'h02);
    chk("R6 first bit early", {7'b0, miso_o}, 8'h01);
    s_bits(1'b0, 1'b0, 8'h6B, got);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 slave tx ph0", got, 8'hA5);
    rd(2'd1, v); chk("R5 done ph0", v, 8'h80);
    rd(2'd2, v); chk("R5 slave rx ph0", v, 8'h6B);

    // R5 slave phase 1, polarity 1
    wr(2'd0, 8'hD8);
    sck_i = 1'b1;
    wr(2'd2, 8'h3C);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    s_bits(1'b1, 1'b1, 8'hC5, got);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 slave tx ph1", got, 8'h3C);
    rd(2'd1, v); chk("R5 done ph1", v, 8'h80);
    rd(2'd2, v); chk("R5 slave rx ph1", v, 8'hC5);

    // R7 slave collision
    wr(2'd0, 8'hC0);
    sck_i = 1'b0;
    wr(2'd2, 8'h11);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h99);
    s_bits(1'b0, 1'b0, 8'h22, got);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 slave byte unchanged", got, 8'h11);
    rd(2'd1, v); chk("R7 slave collision", v, 8'hC0);
    rd(2'd2, v); chk("R7 slave rx", v, 8'h22);

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule